// File: doc/BRIEF.md
# Synchronized Trigger Routing Crossbar

The block drives eight backplane trigger outputs and one star trigger output from a shared pool of trigger sources. Every output has its own route. A route picks one source, can resample it at a synchronization rate, and has its own drive enable. The source pool holds:

- six front-panel lines, three differential lines and a differential star input;
- the eight trigger lines as seen on the backplane, and the star line;
- a software trigger pulse;
- the synchronization clock itself;
- constant low and constant high.

All logic runs on one fabric clock. The four candidate base clocks arrive as one-cycle tick enables in that clock domain. One base is chosen for the whole block. It feeds two power-of-two dividers, and these produce enable pulses. A route resamples at full base rate, at the first divider rate or at the second divider rate. Configuration arrives through a small write port. A write is held pending until a safe boundary, so that a change never cuts an output pulse short.

Top module: `trig_xbar`

## Requirements
- R1: After reset every drive enable is low. Every route is unsynchronized at full rate and passes front-panel line 0. The divider counter starts at zero.
- R2: Bits [9:8] of the global word select which `base_clk_i` bit acts as the base tick for all routes. Ticks on the other base inputs have no effect.
- R3: The source code is route word bits [8:4]: 0–5 front-panel lines, 6–8 differential lines, 9–16 trigger lines 0–7, 17 star line, 18 software trigger, 19 synchronization clock, 20 differential star input, 21 low, 22 high, and any higher code gives low. When bit 1 (sync) is clear, the selected source reaches the output in the same cycle.
- R4: Global word bits [7:4] and [3:0] are the exponents of the first and second divider. Values above 9 act as 9. A divider pulses on a base tick when the free-running base-tick counter's low n bits are all ones, so it pulses once every 2^n ticks. Source 19 is a level that toggles on each pulse of the route's own rate.
- R5: Route word bits [3:2] select the rate: 0 full, 1 first divider, 2 second divider, 3 full. When sync is set, the output register captures the source only on the pulses of that rate.
- R6: A trigger route whose source is its own line (code 9+i), or the star route with code 17, holds its last registered value.
- R7: Route word bit 0 drives the route's output enable. When it is clear, the line is left undriven.
- R8: A one-cycle `sw_trig_i` pulse appears on a route selecting code 18 for exactly one period of that route's enable, starting at the route's next enable.
- R9: A route write takes effect at the route's next enable pulse at its current rate. A global write takes effect on a base tick where both dividers pulse. Until then the old configuration stays in force.
- R10: Write addresses 0–7 reach trigger routes 0–7, address 8 reaches the star route and address 9 reaches the global word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_clk_i | input | 4 | Tick enables of the four candidate base clocks |
| fp_i | input | 6 | Front-panel trigger lines |
| diff_i | input | 3 | Differential trigger lines |
| trig_i | input | 8 | Backplane trigger line levels |
| star_i | input | 1 | Star line level |
| dstar_i | input | 1 | Differential star input |
| sw_trig_i | input | 1 | Software trigger pulse |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 4 | Route or global word address |
| wr_data_i | input | 10 | Configuration write data |
| trig_o | output | 8 | Trigger route values |
| trig_oe_o | output | 8 | Trigger drive enables, low means high impedance |
| star_o | output | 1 | Star route value |
| star_oe_o | output | 1 | Star drive enable (sets the star line direction) |

## Verification
Directed patterns come first, and each one separates a specific kind of fault:

- Ticking only the selected base input, and then only the others, shows whether the base select is honoured.
- Counting the toggles of the synchronization clock source over 32 cycles at exponent 2 shows whether the divider period is wrong.
- A single software pulse counted over 16 cycles catches a stretch of the wrong length.
- A star-route write that changes only the star enable exposes a wrong address decode.

Random traffic then mixes base ticks, input levels, software pulses and writes with small or out-of-range exponents. This exercises self-selection, pending writes and every rate against a cycle-level model.

// File: rtl/trig_xbar_pkg.sv
package trig_xbar_pkg;
  localparam logic [1:0] RATE_FULL = 2'd0;
  localparam logic [1:0] RATE_DIV1 = 2'd1;
  localparam logic [1:0] RATE_DIV2 = 2'd2;

  localparam int CFG_DRV  = 0;
  localparam int CFG_SYNC = 1;
  localparam int CFG_RATE = 2;
  localparam int CFG_SRC  = 4;
endpackage

// File: rtl/trig_xbar_div.sv
module trig_xbar_div #(
  parameter int MAX_EXP = 9,
  localparam int EXP_W  = $clog2(MAX_EXP + 1),
  localparam int CNT_W  = MAX_EXP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [EXP_W-1:0] exp1_i,
  input  logic [EXP_W-1:0] exp2_i,
  output logic [2:0]       en_o,
  output logic [2:0]       tg_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [1:0][EXP_W-1:0] exps;

  assign exps = {exp2_i, exp1_i};
  assign en_o[0] = tick_i;

  for (genvar k = 0; k < 2; k++) begin : g_div
    logic [EXP_W-1:0] n_c;
    logic [CNT_W-1:0] mask;
    always_comb begin
      n_c  = (exps[k] > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exps[k];
      mask = ~({CNT_W{1'b1}} << n_c);
    end
    assign en_o[k+1] = tick_i & ((cnt_q & mask) == mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tg_o  <= '0;
    end else begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
      tg_o <= tg_o ^ en_o;
    end
  end
endmodule

// File: rtl/trig_xbar_route.sv
module trig_xbar_route import trig_xbar_pkg::*; #(
  parameter int SRC_N    = 23,
  parameter int SRC_W    = 5,
  parameter int SELF_SRC = 9,
  parameter int SW_SRC   = 18,
  parameter int SCLK_SRC = 19,
  localparam int CFG_W   = SRC_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_i,
  input  logic [2:0]       en_i,
  input  logic [2:0]       tg_i,
  input  logic             sw_i,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             val_o,
  output logic             oe_o,
  output logic             ren_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             sw_o
);
  logic [CFG_W-1:0] cfg_q, pend_q;
  logic             pend_v;
  logic [SRC_W-1:0] src;
  logic [1:0]       rate;
  logic             sync, ren, sclk, self_sel, sel, q;
  logic             sw_pend, sw_act;
  logic [SRC_N-1:0] vec;

  always_comb begin
    src  = cfg_q[CFG_W-1:CFG_SRC];
    rate = cfg_q[CFG_RATE+:2];
    sync = cfg_q[CFG_SYNC];
    unique case (rate)
      RATE_DIV1: begin ren = en_i[1]; sclk = tg_i[1]; end
      RATE_DIV2: begin ren = en_i[2]; sclk = tg_i[2]; end
      default:   begin ren = en_i[0]; sclk = tg_i[0]; end
    endcase
    vec = src_i;
    vec[SW_SRC]   = sw_act;
    vec[SCLK_SRC] = sclk;
    sel = 1'b0;
    for (int k = 0; k < SRC_N; k++)
      if (src == SRC_W'(k)) sel = vec[k];
    self_sel = (src == SRC_W'(SELF_SRC));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      pend_q  <= '0;
      pend_v  <= 1'b0;
      q       <= 1'b0;
      sw_pend <= 1'b0;
      sw_act  <= 1'b0;
    end else begin
      if (!self_sel && (!sync || ren)) q <= sel;
      if (ren) begin
        sw_act  <= sw_pend | sw_i;
        sw_pend <= 1'b0;
      end else if (sw_i) begin
        sw_pend <= 1'b1;
      end
      if (ren && pend_v) cfg_q <= pend_q;
      if (wr_i) begin
        pend_q <= wdata_i;
        pend_v <= 1'b1;
      end else if (ren) begin
        pend_v <= 1'b0;
      end
    end
  end

  assign val_o = (sync || self_sel) ? q : sel;
  assign oe_o  = cfg_q[CFG_DRV];
  assign ren_o = ren;
  assign cfg_o = cfg_q;
  assign sw_o  = sw_act;
endmodule

// File: rtl/trig_xbar.sv
module trig_xbar #(
  parameter int N_FP    = 6,
  parameter int N_DIFF  = 3,
  parameter int N_TRIG  = 8,
  parameter int N_BASE  = 4,
  parameter int MAX_EXP = 9,
  localparam int N_ROUTE = N_TRIG + 1,
  localparam int SRC_N   = N_FP + N_DIFF + N_TRIG + 6,
  localparam int SRC_W   = $clog2(SRC_N),
  localparam int CFG_W   = SRC_W + 4,
  localparam int BSEL_W  = $clog2(N_BASE),
  localparam int EXP_W   = $clog2(MAX_EXP + 1),
  localparam int GCFG_W  = BSEL_W + 2 * EXP_W,
  localparam int DW      = (CFG_W > GCFG_W) ? CFG_W : GCFG_W,
  localparam int AW      = $clog2(N_ROUTE + 1)
) (
  input  logic [0:0]        clk_i,
  input  logic              rst_ni,
  input  logic [N_BASE-1:0] base_clk_i,
  input  logic [N_FP-1:0]   fp_i,
  input  logic [N_DIFF-1:0] diff_i,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              star_i,
  input  logic              dstar_i,
  input  logic              sw_trig_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [N_TRIG-1:0] trig_o,
  output logic [N_TRIG-1:0] trig_oe_o,
  output logic              star_o,
  output logic              star_oe_o
);
  localparam int TRIG0    = N_FP + N_DIFF;
  localparam int STAR_SRC = TRIG0 + N_TRIG;
  localparam int SW_SRC   = STAR_SRC + 1;
  localparam int SCLK_SRC = SW_SRC + 1;

  logic [SRC_N-1:0]  src_vec;
  logic [GCFG_W-1:0] gbl_act, gbl_pend;
  logic              gbl_pv, base_tick, commit;
  logic [BSEL_W-1:0] base_sel;
  logic [EXP_W-1:0]  exp1, exp2;
  logic [2:0]        div_en, div_tg;
  logic [N_ROUTE-1:0] rt_val, rt_oe, rt_en, rt_sw;
  logic [N_ROUTE-1:0][CFG_W-1:0] rt_cfg;

  // high, low, dstar, sclk slot, sw slot, star, trig, diff, front panel
  assign src_vec = {1'b1, 1'b0, dstar_i, 1'b0, 1'b0, star_i, trig_i, diff_i, fp_i};

  assign base_sel  = gbl_act[GCFG_W-1 -: BSEL_W];
  assign exp1      = gbl_act[2*EXP_W-1 -: EXP_W];
  assign exp2      = gbl_act[EXP_W-1:0];
  assign base_tick = base_clk_i[base_sel];
  assign commit    = div_en[1] & div_en[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gbl_act  <= '0;
      gbl_pend <= '0;
      gbl_pv   <= 1'b0;
    end else begin
      if (commit && gbl_pv) gbl_act <= gbl_pend;
      if (wr_en_i && wr_addr_i == AW'(N_ROUTE)) begin
        gbl_pend <= wr_data_i[GCFG_W-1:0];
        gbl_pv   <= 1'b1;
      end else if (commit) begin
        gbl_pv <= 1'b0;
      end
    end
  end

  trig_xbar_div #(.MAX_EXP(MAX_EXP)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (base_tick),
    .exp1_i (exp1),
    .exp2_i (exp2),
    .en_o   (div_en),
    .tg_o   (div_tg)
  );

  for (genvar g = 0; g < N_ROUTE; g++) begin : g_route
    trig_xbar_route #(
      .SRC_N    (SRC_N),
      .SRC_W    (SRC_W),
      .SELF_SRC ((g < N_TRIG) ? TRIG0 + g : STAR_SRC),
      .SW_SRC   (SW_SRC),
      .SCLK_SRC (SCLK_SRC)
    ) u_route (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_vec),
      .en_i    (div_en),
      .tg_i    (div_tg),
      .sw_i    (sw_trig_i),
      .wr_i    (wr_en_i && wr_addr_i == AW'(g)),
      .wdata_i (wr_data_i[CFG_W-1:0]),
      .val_o   (rt_val[g]),
      .oe_o    (rt_oe[g]),
      .ren_o   (rt_en[g]),
      .cfg_o   (rt_cfg[g]),
      .sw_o    (rt_sw[g])
    );
  end

  assign trig_o    = rt_val[N_TRIG-1:0];
  assign trig_oe_o = rt_oe[N_TRIG-1:0];
  assign star_o    = rt_val[N_TRIG];
  assign star_oe_o = rt_oe[N_TRIG];
endmodule

// File: rtl/trig_xbar_chk.sv
module trig_xbar_chk #(
  parameter int N_ROUTE = 9,
  parameter int CFG_W   = 9
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [2:0]                    en_i,
  input logic [2:0]                    tg_i,
  input logic [N_ROUTE-1:0]            ren_i,
  input logic [N_ROUTE-1:0]            val_i,
  input logic [N_ROUTE-1:0]            sw_i,
  input logic [N_ROUTE-1:0][CFG_W-1:0] cfg_i
);
  a_r4_div_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i[1] || en_i[2]) |-> en_i[0]);

  for (genvar k = 0; k < 3; k++) begin : g_tg
    a_r4_sclk_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i[k] |=> (tg_i[k] != $past(tg_i[k])));
    a_r4_sclk_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[k] |=> $stable(tg_i[k]));
  end

  for (genvar i = 0; i < N_ROUTE; i++) begin : g_rt
    a_r5_sync_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i[i][1] && !ren_i[i]) |=> $stable(val_i[i]));
    a_r9_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ren_i[i] |=> $stable(cfg_i[i]));
    a_r8_sw_at_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sw_i[i]) |-> $past(ren_i[i]));
  end
endmodule

bind trig_xbar trig_xbar_chk #(.N_ROUTE(N_TRIG + 1), .CFG_W(CFG_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (div_en),
  .tg_i   (div_tg),
  .ren_i  (rt_en),
  .val_i  (rt_val),
  .sw_i   (rt_sw),
  .cfg_i  (rt_cfg)
);

// File: tb/trig_xbar_test.sv
`timescale 1ns/1ps
module trig_xbar_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] base;
  logic [5:0] fp;
  logic [2:0] df;
  logic [7:0] tr;
  logic       st, ds, sw, we;
  logic [3:0] wa;
  logic [9:0] wd;
  logic [7:0] trig_o, trig_oe;
  logic       star_o, star_oe;

  int n_chk = 0;
  int n_err = 0;

  trig_xbar uut (
    .clk_i(clk), .rst_ni(rst_n), .base_clk_i(base), .fp_i(fp), .diff_i(df),
    .trig_i(tr), .star_i(st), .dstar_i(ds), .sw_trig_i(sw), .wr_en_i(we),
    .wr_addr_i(wa), .wr_data_i(wd), .trig_o(trig_o), .trig_oe_o(trig_oe),
    .star_o(star_o), .star_oe_o(star_oe)
  );

  // cycle-level reference state
  logic [8:0] m_cnt;
  logic [2:0] m_tg;
  logic [9:0] m_gact, m_gpend;
  logic       m_gpv;
  logic [8:0] m_cfg [9];
  logic [8:0] m_pend [9];
  logic       m_pv [9];
  logic       m_q [9];
  logic       m_swp [9];
  logic       m_swa [9];

  function automatic logic m_en(int k);
    logic t;
    int n;
    t = base[m_gact[9:8]];
    if (k == 0) return t;
    n = (k == 1) ? int'(m_gact[7:4]) : int'(m_gact[3:0]);
    if (n > 9) n = 9;
    return t && ((int'(m_cnt) % (1 << n)) == ((1 << n) - 1));
  endfunction

  function automatic int m_ri(int r);
    if (m_cfg[r][3:2] == 2'd1) return 1;
    if (m_cfg[r][3:2] == 2'd2) return 2;
    return 0;
  endfunction

  function automatic logic m_sel(int r);
    int s;
    s = int'(m_cfg[r][8:4]);
    if (s < 6) return fp[s];
    if (s < 9) return df[s-6];
    if (s < 17) return tr[s-9];
    if (s == 17) return st;
    if (s == 18) return m_swa[r];
    if (s == 19) return m_tg[m_ri(r)];
    if (s == 20) return ds;
    if (s == 22) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic m_self(int r);
    int s;
    s = int'(m_cfg[r][8:4]);
    return (r < 8) ? (s == 9 + r) : (s == 17);
  endfunction

  function automatic logic m_out(int r);
    return (m_cfg[r][1] || m_self(r)) ? m_q[r] : m_sel(r);
  endfunction

  function automatic string m_tag(int r);
    int s;
    s = int'(m_cfg[r][8:4]);
    if (m_pv[r]) return "R9";
    if (m_self(r)) return "R6";
    if (s == 18) return "R8";
    if (s == 19) return "R4";
    if (m_cfg[r][1]) return "R5";
    return "R3";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_tg <= '0; m_gact <= '0; m_gpend <= '0; m_gpv <= 1'b0;
      for (int r = 0; r < 9; r++) begin
        m_cfg[r] <= '0; m_pend[r] <= '0; m_pv[r] <= 1'b0;
        m_q[r] <= 1'b0; m_swp[r] <= 1'b0; m_swa[r] <= 1'b0;
      end
    end else begin : upd
      logic [2:0] e;
      logic re;
      for (int k = 0; k < 3; k++) e[k] = m_en(k);
      if (e[0]) m_cnt <= m_cnt + 1'b1;
      for (int k = 0; k < 3; k++) if (e[k]) m_tg[k] <= ~m_tg[k];
      if (m_gpv && e[1] && e[2]) m_gact <= m_gpend;
      if (we && wa == 4'd9) begin m_gpend <= wd; m_gpv <= 1'b1; end
      else if (e[1] && e[2]) m_gpv <= 1'b0;
      for (int r = 0; r < 9; r++) begin
        re = e[m_ri(r)];
        if (!m_self(r) && (!m_cfg[r][1] || re)) m_q[r] <= m_sel(r);
        if (re) begin m_swa[r] <= m_swp[r] | sw; m_swp[r] <= 1'b0; end
        else if (sw) m_swp[r] <= 1'b1;
        if (re && m_pv[r]) m_cfg[r] <= m_pend[r];
        if (we && wa == 4'(r)) begin m_pend[r] <= wd[8:0]; m_pv[r] <= 1'b1; end
        else if (re) m_pv[r] <= 1'b0;
      end
    end
  end

  task automatic chk(string tag, int r, logic [31:0] got, logic [31:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_err++;
      $display("FAIL %s route %0d: got %0h expected %0h", tag, r, got, expv);
    end
  endtask

  task automatic check_all();
    for (int r = 0; r < 9; r++) begin
      chk(m_tag(r), r, 32'(r < 8 ? trig_o[r] : star_o), 32'(m_out(r)));
      chk("R7", r, 32'(r < 8 ? trig_oe[r] : star_oe), 32'(m_cfg[r][0]));
    end
  endtask

  task automatic step();
    #1 check_all();
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [9:0] d);
    we = 1'b1; wa = a; wd = d;
    step();
    we = 1'b0;
    step();
  endtask

  function automatic logic [3:0] rnd_exp();
    if ($urandom % 8 == 0) return 4'(10 + $urandom % 6);
    return 4'($urandom % 4);
  endfunction

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int cnt;
    logic prev;
    void'($urandom(32'd4242));
    base = 4'hF; fp = '0; df = '0; tr = '0; st = 0; ds = 0; sw = 0;
    we = 0; wa = '0; wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", 0, 32'(trig_oe), 32'h0);
    chk("R1", 8, 32'(star_oe), 32'h0);
    chk("R1", 0, 32'({trig_o, star_o}), 32'h0);
    @(negedge clk);

    // R2: only the selected base input advances the sync clock
    wr(4'd9, {2'd1, 4'd0, 4'd0});
    wr(4'd0, {1'b0, 5'd19, 2'd0, 1'b0, 1'b1});
    repeat (3) step();
    base = 4'b0010;
    cnt = 0; prev = trig_o[0];
    for (int i = 0; i < 10; i++) begin
      step();
      if (trig_o[0] != prev) cnt++;
      prev = trig_o[0];
    end
    chk("R2", 0, 32'(cnt), 32'd10);
    base = 4'b1101;
    cnt = 0; prev = trig_o[0];
    for (int i = 0; i < 10; i++) begin
      step();
      if (trig_o[0] != prev) cnt++;
      prev = trig_o[0];
    end
    chk("R2", 0, 32'(cnt), 32'd0);

    // R4: exponent 2 -> toggle every 4 ticks
    base = 4'hF;
    wr(4'd9, {2'd1, 4'd2, 4'd0});
    wr(4'd0, {1'b0, 5'd19, 2'd1, 1'b0, 1'b1});
    repeat (8) step();
    cnt = 0; prev = trig_o[0];
    for (int i = 0; i < 32; i++) begin
      step();
      if (trig_o[0] != prev) cnt++;
      prev = trig_o[0];
    end
    chk("R4", 0, 32'(cnt), 32'd8);

    // R8: one software pulse spans one divider period
    wr(4'd2, {1'b0, 5'd18, 2'd1, 1'b0, 1'b1});
    repeat (8) step();
    sw = 1'b1; step(); sw = 1'b0;
    cnt = 0;
    for (int i = 0; i < 16; i++) begin
      step();
      if (trig_o[2]) cnt++;
    end
    chk("R8", 2, 32'(cnt), 32'd4);

    // R10: address 8 reaches the star route only
    wr(4'd8, {1'b0, 5'd22, 2'd0, 1'b0, 1'b1});
    repeat (4) step();
    chk("R10", 8, 32'({star_o, star_oe}), 32'b11);
    chk("R10", 8, 32'(trig_oe), 32'h05);

    // R6: route 1 latched high, then self-selected
    wr(4'd1, {1'b0, 5'd22, 2'd0, 1'b0, 1'b1});
    repeat (4) step();
    wr(4'd1, {1'b0, 5'd10, 2'd0, 1'b0, 1'b1});
    tr = 8'h00;
    repeat (6) step();
    chk("R6", 1, 32'(trig_o[1]), 32'd1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      base = 4'($urandom) | 4'($urandom);
      fp = 6'($urandom); df = 3'($urandom); tr = 8'($urandom);
      st = 1'($urandom); ds = 1'($urandom);
      sw = ($urandom % 16 == 0);
      we = ($urandom % 12 == 0);
      wa = 4'($urandom % 10);
      if (wa == 4'd9) wd = {2'($urandom), rnd_exp(), rnd_exp()};
      else wd = {1'b0, 5'($urandom % 25), 2'($urandom), 2'($urandom)};
      step();
    end
    we = 1'b0; sw = 1'b0;
    step();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule